// File: doc/BRIEF.md
# Programmable Asynchronous Serial Port

This block is a byte-wide serial transmitter and receiver that a processor drives through a small parallel bus. A chip select, a read strobe, a write strobe and a control/data select line steer every access. Data accesses move characters to and from the serial line. Control accesses set up the line format and the operating command, and return a status byte. The bus is synchronous: every cycle in which select and a strobe are both low counts as one access.

After reset, the block waits for a format byte on the control path. That byte sets the character length, the parity, the number of stop bits and the number of baud-enable pulses per bit. Every later control write is an operating command. The command enables the transmitter and the receiver, drives the two modem outputs, clears the error flags, forces a break on the line, or returns the block to waiting for a new format byte. A single shared baud-enable input times both directions.

Top module: `aser_port`

## Requirements
- R1: After reset, txd is high, txempty is high, txrdy and rxrdy are low, brk_det is low, rts_n and dtr_n are high, and the status byte reads 8'h05.
- R2: The first control write (cs_n, wr_n low, cd high) after reset is the format byte. Its fields are: bits [1:0] select 1, 16 or 64 baud-enable pulses per bit (00, 01, other); bits [3:2] give the data bits minus 5; bit 4 enables parity; bit 5 selects even parity (0 selects odd); bit 6 selects two stop bits. Every later control write is a command, with these bits: 0 transmit enable, 1 DTR, 2 receive enable, 3 send break, 4 error reset, 5 RTS, 6 return to format wait. A return to format wait clears the command and all transmit and receive state.
- R3: With cd low, a write loads a transmit character and a read returns the last received character. With cd high, a read returns status: bit0 transmit buffer free, bit1 received character ready, bit2 transmitter empty, bit3 parity error, bit4 overrun, bit5 framing error, bit6 break detected, bit7 DSR asserted (dsr_n low).
- R4: A transmitted character is one low start bit, the data bits LSB first, an optional parity bit (even parity makes the total count of ones even) and one or two high stop bits. Each bit lasts the selected number of baud-enable pulses.
- R5: The txrdy pin is high only when the transmit buffer is free, transmit is enabled and cts_n is low. Status bit0 ignores cts_n and the enable. A data write clears both. A character starts only while transmit is enabled and cts_n is low.
- R6: txempty is high once the buffer and the shifter are both empty. A data write clears it in the next cycle.
- R7: txd stays low for as long as send break is commanded. With no character in progress, txd is high.
- R8: With receive enabled, a falling edge on rxd is confirmed low at mid-bit (for 16 and 64 pulses per bit), and each data bit is sampled at its centre. A completed character sets rxrdy, and a data read clears it. A glitch shorter than half a bit starts no character. With receive disabled, no character is accepted.
- R9: A received parity bit that does not match the selected parity sets the parity error status bit.
- R10: A stop bit sampled low sets the framing error status bit.
- R11: A character that completes while rxrdy is still set replaces the old one and sets the overrun status bit.
- R12: brk_det rises when a character of all zero bits has a low stop bit. It falls once rxd returns high.
- R13: A command with the error-reset bit set clears the parity, overrun and framing status bits.
- R14: rts_n and dtr_n are the inverses of the RTS and DTR command bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| baud_en | input | 1 | Baud enable pulse shared by both directions |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| cd | input | 1 | 1 selects control/status, 0 selects data |
| din | input | 8 | Write data |
| dout | output | 8 | Read data (status or received character) |
| txd | output | 1 | Serial transmit line |
| txrdy | output | 1 | Transmit buffer free and transmitter allowed to send |
| txempty | output | 1 | Nothing left to send |
| rxd | input | 1 | Serial receive line |
| rxrdy | output | 1 | Received character waiting |
| brk_det | output | 1 | Break seen on the receive line |
| cts_n | input | 1 | Clear to send, active low |
| dsr_n | input | 1 | Data set ready, active low |
| rts_n | output | 1 | Request to send, active low |
| dtr_n | output | 1 | Data terminal ready, active low |

## Verification
The assertions check on every cycle that a frame opens with a low start bit and closes on a high stop bit, that a data write takes away both transmit ready indications, that rxrdy rises only at the stop-bit sample, that overrun rises only over an unread character, and that the format can change only while the block waits for it. The bench scenarios show what no single cycle shows. These are the full frame layout under every combination of length, parity, stop count and bit rate, with the receiver fed back from the transmitter, plus held-off sending under cts_n, parity, framing and overrun errors, break on both lines, glitch rejection and the mode-then-command ordering.

// File: rtl/aser_pkg.sv
package aser_pkg;
    localparam int DATA_W  = 8;
    localparam int MAX_DIV = 64;
    localparam int CNT_W   = $clog2(MAX_DIV);
    localparam int FRAME_W = DATA_W + 4;
    localparam int BITS_W  = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic       stop2;
        logic       par_even;
        logic       par_en;
        logic [1:0] len;
        logic [1:0] fac;
    } mode_t;

    function automatic logic [CNT_W:0] bit_div(input logic [1:0] fac);
        case (fac)
            2'd0:    return (CNT_W+1)'(1);
            2'd1:    return (CNT_W+1)'(16);
            default: return (CNT_W+1)'(64);
        endcase
    endfunction

    function automatic logic [BITS_W-1:0] data_bits(input logic [1:0] len);
        return BITS_W'(5) + BITS_W'(len);
    endfunction
endpackage

// File: rtl/aser_tx.sv
module aser_tx
    import aser_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  mode_t             mode,
    input  logic              go_ok,
    input  logic              brk,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              txd,
    output logic              hold_full,
    output logic              busy
);
    typedef struct packed {
        logic [DATA_W-1:0]  hold;
        logic               full;
        logic               busy;
        logic [FRAME_W-1:0] frame;
        logic [BITS_W-1:0]  left;
        logic [CNT_W-1:0]   cnt;
    } tx_st_t;

    tx_st_t q, d;
    logic [FRAME_W-1:0] fr;
    logic [BITS_W-1:0]  nd, nb;
    logic [CNT_W:0]     div;
    logic               pacc, pbit;

    always_comb begin
        div  = bit_div(mode.fac);
        nd   = data_bits(mode.len);
        nb   = BITS_W'(2) + nd + BITS_W'(mode.par_en) + BITS_W'(mode.stop2);
        pacc = 1'b0;
        fr   = '1;
        fr[0] = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < int'(nd)) begin
                fr[i+1] = q.hold[i];
                pacc    = pacc ^ q.hold[i];
            end
        end
        pbit = mode.par_even ? pacc : ~pacc;
        if (mode.par_en) fr[nd + BITS_W'(1)] = pbit;

        d = q;
        if (q.busy && tick) begin
            if (q.cnt == '0) begin
                if (q.left == BITS_W'(1)) begin
                    d.busy = 1'b0;
                end else begin
                    d.frame = {1'b1, q.frame[FRAME_W-1:1]};
                    d.left  = q.left - BITS_W'(1);
                    d.cnt   = CNT_W'(div - 1'b1);
                end
            end else begin
                d.cnt = q.cnt - CNT_W'(1);
            end
        end else if (!q.busy && q.full && go_ok && tick) begin
            d.busy  = 1'b1;
            d.full  = 1'b0;
            d.frame = fr;
            d.left  = nb;
            d.cnt   = CNT_W'(div - 1'b1);
        end
        if (wr) begin
            d.hold = wdata;
            d.full = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign txd       = brk ? 1'b0 : (q.busy ? q.frame[0] : 1'b1);
    assign hold_full = q.full;
    assign busy      = q.busy;

    a_r4_start_bit_low: assert property (@(posedge clk) disable iff (rst)
        $rose(q.busy) && !brk |-> !txd);
    a_r4_ends_on_stop: assert property (@(posedge clk) disable iff (rst)
        $fell(q.busy) && !$past(brk) |-> $past(txd));
    a_r7_break_holds_low: assert property (@(posedge clk) disable iff (rst)
        brk |-> !txd);
endmodule

// File: rtl/aser_rx.sv
module aser_rx
    import aser_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  mode_t             mode,
    input  logic              en,
    input  logic              rxd,
    input  logic              rd,
    input  logic              err_clr,
    output logic [DATA_W-1:0] data,
    output logic              rdy,
    output logic              perr,
    output logic              oerr,
    output logic              ferr,
    output logic              brk
);
    typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_PAR, R_STOP, R_HOLD} rx_state_t;

    typedef struct packed {
        rx_state_t         st;
        logic [CNT_W-1:0]  cnt;
        logic [BITS_W-1:0] idx;
        logic [DATA_W-1:0] sh;
        logic              pbit;
        logic [DATA_W-1:0] data;
        logic              rdy;
        logic              perr;
        logic              oerr;
        logic              ferr;
        logic              brk;
    } rx_st_t;

    rx_st_t q, d;
    logic [CNT_W:0]     div;
    logic [BITS_W-1:0]  nd;
    logic [DATA_W-1:0]  word;
    logic [CNT_W-1:0]   reload;

    always_comb begin
        div    = bit_div(mode.fac);
        nd     = data_bits(mode.len);
        reload = CNT_W'(div - 1'b1);
        word   = q.sh >> (BITS_W'(DATA_W) - nd);

        d = q;
        if (rd) d.rdy = 1'b0;
        if (err_clr) begin
            d.perr = 1'b0;
            d.oerr = 1'b0;
            d.ferr = 1'b0;
        end
        if (q.brk && rxd) d.brk = 1'b0;

        if (tick) begin
            case (q.st)
                R_IDLE: if (en && !rxd) begin
                    d.idx = '0;
                    if (div == (CNT_W+1)'(1)) begin
                        d.st  = R_DATA;
                        d.cnt = '0;
                    end else begin
                        d.st  = R_START;
                        d.cnt = CNT_W'(div >> 1);
                    end
                end
                R_START: begin
                    if (q.cnt != '0) d.cnt = q.cnt - CNT_W'(1);
                    else if (rxd)    d.st  = R_IDLE;
                    else begin
                        d.st  = R_DATA;
                        d.cnt = reload;
                    end
                end
                R_DATA: begin
                    if (q.cnt != '0) d.cnt = q.cnt - CNT_W'(1);
                    else begin
                        d.sh  = {rxd, q.sh[DATA_W-1:1]};
                        d.cnt = reload;
                        if (q.idx == nd - BITS_W'(1)) d.st = mode.par_en ? R_PAR : R_STOP;
                        else                          d.idx = q.idx + BITS_W'(1);
                    end
                end
                R_PAR: begin
                    if (q.cnt != '0) d.cnt = q.cnt - CNT_W'(1);
                    else begin
                        d.pbit = rxd;
                        d.cnt  = reload;
                        d.st   = R_STOP;
                    end
                end
                R_STOP: begin
                    if (q.cnt != '0) d.cnt = q.cnt - CNT_W'(1);
                    else begin
                        d.data = word;
                        d.rdy  = 1'b1;
                        if (q.rdy && !rd) d.oerr = 1'b1;
                        if (mode.par_en && ((^word) ^ q.pbit ^ !mode.par_even)) d.perr = 1'b1;
                        if (!rxd) begin
                            d.ferr = 1'b1;
                            d.st   = R_HOLD;
                            if (word == '0 && (!mode.par_en || !q.pbit)) d.brk = 1'b1;
                        end else begin
                            d.st = R_IDLE;
                        end
                    end
                end
                R_HOLD: if (rxd) d.st = R_IDLE;
                default: d.st = R_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign data = q.data;
    assign rdy  = q.rdy;
    assign perr = q.perr;
    assign oerr = q.oerr;
    assign ferr = q.ferr;
    assign brk  = q.brk;

    a_r8_ready_after_stop: assert property (@(posedge clk) disable iff (rst)
        $rose(q.rdy) |-> $past(q.st) == R_STOP);
    a_r11_overrun_needs_unread: assert property (@(posedge clk) disable iff (rst)
        $rose(q.oerr) |-> $past(q.rdy));
    a_r12_break_only_on_low_line: assert property (@(posedge clk) disable iff (rst)
        $rose(q.brk) |-> $past(!rxd));
endmodule

// File: rtl/aser_port.sv
module aser_port
    import aser_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_en,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              cd,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              txd,
    output logic              txrdy,
    output logic              txempty,
    input  logic              rxd,
    output logic              rxrdy,
    output logic              brk_det,
    input  logic              cts_n,
    input  logic              dsr_n,
    output logic              rts_n,
    output logic              dtr_n
);
    localparam int C_TXEN = 0, C_DTR = 1, C_RXEN = 2, C_BRK = 3, C_ERST = 4, C_RTS = 5, C_IRST = 6;

    typedef struct packed {
        mode_t             mode;
        logic              armed;
        logic [DATA_W-1:0] cmd;
    } ctl_st_t;

    ctl_st_t q, d;
    logic wr_ctl, wr_dat, rd_dat, soft_rst, err_clr, sub_rst;
    logic hold_full, tx_busy;
    logic [DATA_W-1:0] rx_data;
    logic rx_perr, rx_oerr, rx_ferr;

    always_comb begin
        wr_ctl   = !cs_n && !wr_n && cd;
        wr_dat   = !cs_n && !wr_n && !cd;
        rd_dat   = !cs_n && !rd_n && !cd;
        soft_rst = wr_ctl && q.armed && din[C_IRST];
        err_clr  = wr_ctl && q.armed && din[C_ERST];

        d = q;
        if (wr_ctl) begin
            if (!q.armed) begin
                d.mode  = mode_t'(din[6:0]);
                d.armed = 1'b1;
            end else if (din[C_IRST]) begin
                d.armed = 1'b0;
                d.cmd   = '0;
            end else begin
                d.cmd = din;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign sub_rst = rst || soft_rst;

    aser_tx u_tx (
        .clk       (clk),
        .rst       (sub_rst),
        .tick      (baud_en),
        .mode      (q.mode),
        .go_ok     (q.cmd[C_TXEN] && !cts_n),
        .brk       (q.cmd[C_BRK]),
        .wr        (wr_dat),
        .wdata     (din),
        .txd       (txd),
        .hold_full (hold_full),
        .busy      (tx_busy)
    );

    aser_rx u_rx (
        .clk     (clk),
        .rst     (sub_rst),
        .tick    (baud_en),
        .mode    (q.mode),
        .en      (q.cmd[C_RXEN]),
        .rxd     (rxd),
        .rd      (rd_dat),
        .err_clr (err_clr),
        .data    (rx_data),
        .rdy     (rxrdy),
        .perr    (rx_perr),
        .oerr    (rx_oerr),
        .ferr    (rx_ferr),
        .brk     (brk_det)
    );

    assign txrdy   = !hold_full && q.cmd[C_TXEN] && !cts_n;
    assign txempty = !hold_full && !tx_busy;
    assign rts_n   = !q.cmd[C_RTS];
    assign dtr_n   = !q.cmd[C_DTR];
    assign dout    = cd ? {!dsr_n, brk_det, rx_ferr, rx_oerr, rx_perr, txempty, rxrdy, !hold_full}
                        : rx_data;

    a_r2_mode_only_when_waiting: assert property (@(posedge clk) disable iff (rst)
        !$stable(q.mode) |-> !$past(q.armed));
    a_r6_write_clears_empty: assert property (@(posedge clk) disable iff (rst)
        wr_dat |=> !txempty);
    a_r5_write_clears_ready: assert property (@(posedge clk) disable iff (rst)
        wr_dat |=> !txrdy);
    a_r13_errors_cleared: assert property (@(posedge clk) disable iff (rst)
        err_clr |=> !rx_perr && !rx_ferr);
endmodule

// File: tb/aser_port_test.sv
module aser_port_test;
    logic clk = 1'b0, rst = 1'b1, cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, cd = 1'b0;
    logic cts_n = 1'b0, dsr_n = 1'b1, loopb = 1'b0, rxd_drv = 1'b1;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic txd, txrdy, txempty, rxrdy, brk_det, rts_n, dtr_n, rxd;
    int total = 0, bad = 0;

    assign rxd = loopb ? txd : rxd_drv;
    always #5 clk = ~clk;

    aser_port uut (
        .clk(clk), .rst(rst), .baud_en(1'b1), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .cd(cd), .din(din), .dout(dout), .txd(txd), .txrdy(txrdy), .txempty(txempty),
        .rxd(rxd), .rxrdy(rxrdy), .brk_det(brk_det), .cts_n(cts_n), .dsr_n(dsr_n),
        .rts_n(rts_n), .dtr_n(dtr_n)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_bus(input logic c, input logic [7:0] v);
        @(negedge clk); cs_n = 1'b0; wr_n = 1'b0; cd = c; din = v;
        @(negedge clk); cs_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic rd_bus(input logic c, output logic [7:0] v);
        @(negedge clk); cs_n = 1'b0; rd_n = 1'b0; cd = c;
        #1 v = dout;
        @(negedge clk); cs_n = 1'b1; rd_n = 1'b1;
    endtask

    function automatic logic par_of(input logic [7:0] v, input int pm);
        return (pm == 2) ? (^v) : ~(^v);
    endfunction

    // pm: 0 none, 1 odd, 2 even
    task automatic catch_tx(input int f, input int nd, input int pm, input int st,
                            input string tag, output logic [7:0] v);
        int w = 0;
        v = 8'h00;
        @(negedge clk);
        while (txd !== 1'b0 && w < 5000) begin @(negedge clk); w++; end
        chk({tag, " R4 start seen"}, int'(txd), 0);
        repeat (f / 2) @(negedge clk);
        chk({tag, " R4 start mid"}, int'(txd), 0);
        for (int i = 0; i < nd; i++) begin
            repeat (f) @(negedge clk);
            v[i] = txd;
        end
        if (pm != 0) begin
            repeat (f) @(negedge clk);
            chk({tag, " R4 parity bit"}, int'(txd), int'(par_of(v, pm)));
        end
        for (int i = 0; i < st; i++) begin
            repeat (f) @(negedge clk);
            chk({tag, " R4 stop bit"}, int'(txd), 1);
        end
    endtask

    task automatic drive_frame(input int f, input int nd, input logic [7:0] v, input int pm,
                               input logic bad_par, input logic stopv);
        @(negedge clk); rxd_drv = 1'b0;
        repeat (f) @(negedge clk);
        for (int i = 0; i < nd; i++) begin
            rxd_drv = v[i];
            repeat (f) @(negedge clk);
        end
        if (pm != 0) begin
            rxd_drv = par_of(v, pm) ^ bad_par;
            repeat (f) @(negedge clk);
        end
        rxd_drv = stopv;
        repeat (f) @(negedge clk);
        rxd_drv = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog all R act=timeout exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] s, r, v, mode;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 txd", int'(txd), 1);
        chk("R1 txempty", int'(txempty), 1);
        chk("R1 txrdy", int'(txrdy), 0);
        chk("R1 rxrdy", int'(rxrdy), 0);
        chk("R1 brk_det", int'(brk_det), 0);
        chk("R1 rts_n", int'(rts_n), 1);
        chk("R1 dtr_n", int'(dtr_n), 1);
        rd_bus(1'b1, s);
        chk("R1 R3 status", int'(s), 8'h05);

        // R2 mode first, then commands; R14 modem lines
        wr_bus(1'b1, 8'h0C);
        wr_bus(1'b1, 8'h23);
        chk("R14 rts_n", int'(rts_n), 0);
        chk("R14 dtr_n", int'(dtr_n), 0);
        wr_bus(1'b1, 8'h27);
        loopb = 1'b1;
        wr_bus(1'b0, 8'hC3);
        catch_tx(1, 8, 0, 1, "R2 second write is command", v);
        chk("R2 R4 frame data", int'(v), 8'hC3);
        repeat (4) @(negedge clk);
        rd_bus(1'b0, r);
        chk("R3 R8 loop data", int'(r), 8'hC3);

        // R5 cts gating, R6 empty
        cts_n = 1'b1;
        @(negedge clk);
        chk("R5 txrdy pin with cts high", int'(txrdy), 0);
        rd_bus(1'b1, s);
        chk("R5 status free ignores cts", int'(s[0]), 1);
        wr_bus(1'b0, 8'h96);
        chk("R6 txempty after write", int'(txempty), 0);
        rd_bus(1'b1, s);
        chk("R5 status free cleared by write", int'(s[0]), 0);
        repeat (20) @(negedge clk);
        chk("R5 no send while cts high", int'(txd), 1);
        cts_n = 1'b0;
        catch_tx(1, 8, 0, 1, "R5 after cts", v);
        chk("R5 frame data", int'(v), 8'h96);
        repeat (4) @(negedge clk);
        chk("R6 txempty after send", int'(txempty), 1);
        chk("R5 txrdy pin free", int'(txrdy), 1);
        rd_bus(1'b0, r);

        // R7 break and disabled idle
        wr_bus(1'b1, 8'h2F);
        repeat (5) @(negedge clk);
        chk("R7 break low", int'(txd), 0);
        repeat (30) @(negedge clk);
        chk("R7 break still low", int'(txd), 0);
        wr_bus(1'b1, 8'h26);
        @(negedge clk);
        chk("R7 disabled idle high", int'(txd), 1);
        chk("R5 txrdy pin disabled", int'(txrdy), 0);
        repeat (4) @(negedge clk);
        rd_bus(1'b0, r);
        wr_bus(1'b1, 8'h37);
        wr_bus(1'b1, 8'h27);

        // R11 overrun, R8 read clears, R13 error reset
        wr_bus(1'b0, 8'h11);
        catch_tx(1, 8, 0, 1, "R11 first", v);
        repeat (4) @(negedge clk);
        wr_bus(1'b0, 8'h22);
        catch_tx(1, 8, 0, 1, "R11 second", v);
        repeat (4) @(negedge clk);
        rd_bus(1'b1, s);
        chk("R11 overrun bit", int'(s[4]), 1);
        chk("R8 rxrdy bit", int'(s[1]), 1);
        rd_bus(1'b0, r);
        chk("R11 newer kept", int'(r), 8'h22);
        chk("R8 rxrdy cleared by read", int'(rxrdy), 0);
        wr_bus(1'b1, 8'h37);
        rd_bus(1'b1, s);
        chk("R13 errors cleared", int'(s[5:3]), 0);

        // R2 return to format wait
        wr_bus(1'b1, 8'h40);
        chk("R2 internal reset clears command", int'(rts_n), 1);
        wr_bus(1'b1, 8'h3C);
        wr_bus(1'b1, 8'h27);
        loopb = 1'b0;

        // R9 parity error
        drive_frame(1, 8, 8'h01, 2, 1'b1, 1'b1);
        repeat (3) @(negedge clk);
        rd_bus(1'b1, s);
        chk("R9 parity error bit", int'(s[3]), 1);
        chk("R9 char ready", int'(s[1]), 1);
        rd_bus(1'b0, r);
        chk("R9 data", int'(r), 8'h01);

        // R10 framing error
        wr_bus(1'b1, 8'h37);
        drive_frame(1, 8, 8'h55, 2, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        rd_bus(1'b1, s);
        chk("R10 framing bit", int'(s[5]), 1);
        chk("R9 good parity no error", int'(s[3]), 0);
        chk("R12 no break on nonzero", int'(brk_det), 0);
        rd_bus(1'b0, r);
        chk("R10 data", int'(r), 8'h55);

        // R12 break detect
        wr_bus(1'b1, 8'h37);
        @(negedge clk); rxd_drv = 1'b0;
        repeat (30) @(negedge clk);
        chk("R12 break detected", int'(brk_det), 1);
        rd_bus(1'b1, s);
        chk("R12 status break bit", int'(s[6]), 1);
        rxd_drv = 1'b1;
        repeat (3) @(negedge clk);
        chk("R12 break cleared", int'(brk_det), 0);
        rd_bus(1'b0, r);

        // R8 receive disabled, R3 dsr status
        wr_bus(1'b1, 8'h23);
        dsr_n = 1'b0;
        drive_frame(1, 8, 8'h5A, 2, 1'b0, 1'b1);
        repeat (3) @(negedge clk);
        rd_bus(1'b1, s);
        chk("R8 disabled no char", int'(s[1]), 0);
        chk("R3 dsr bit", int'(s[7]), 1);
        dsr_n = 1'b1;

        // R8 glitch rejection and centre sampling at 16x
        wr_bus(1'b1, 8'h40);
        wr_bus(1'b1, 8'h0D);
        wr_bus(1'b1, 8'h27);
        @(negedge clk); rxd_drv = 1'b0;
        repeat (3) @(negedge clk);
        rxd_drv = 1'b1;
        repeat (40) @(negedge clk);
        chk("R8 glitch rejected", int'(rxrdy), 0);
        drive_frame(16, 8, 8'hA5, 0, 1'b0, 1'b1);
        repeat (3) @(negedge clk);
        chk("R8 char ready 16x", int'(rxrdy), 1);
        rd_bus(1'b0, r);
        chk("R8 data 16x", int'(r), 8'hA5);

        // R4 sweep over every format, receiver fed from transmitter
        loopb = 1'b1;
        for (int fac = 0; fac < 3; fac++) begin
            for (int len = 0; len < 4; len++) begin
                for (int pm = 0; pm < 3; pm++) begin
                    for (int st = 0; st < 2; st++) begin
                        int f, nd;
                        logic [7:0] mask;
                        f  = (fac == 0) ? 1 : ((fac == 1) ? 16 : 64);
                        nd = len + 5;
                        mask = 8'(8'hFF >> (8 - nd));
                        mode = 8'((st << 6) | (((pm == 2) ? 1 : 0) << 5) |
                                  (((pm != 0) ? 1 : 0) << 4) | (len << 2) | fac);
                        wr_bus(1'b1, 8'h40);
                        wr_bus(1'b1, mode);
                        wr_bus(1'b1, 8'h27);
                        v = 8'((fac * 97 + len * 29 + pm * 13 + st * 7 + 8'h5A)) & mask;
                        wr_bus(1'b0, v);
                        catch_tx(f, nd, pm, st + 1, "R4 sweep", r);
                        chk("R4 sweep tx data", int'(r), int'(v));
                        repeat (f + 4) @(negedge clk);
                        rd_bus(1'b1, s);
                        chk("R8 sweep ready", int'(s[1]), 1);
                        chk("R9 R10 R11 sweep no errors", int'(s[5:3]), 0);
                        rd_bus(1'b0, r);
                        chk("R8 sweep rx data", int'(r), int'(v));
                    end
                end
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule